// File: doc/BRIEF.md
# DES Round Subkey Generator

This block expands a 64-bit DES key into the sixteen 48-bit round subkeys that an iterative DES data path consumes, one subkey per round. A load strobe captures a key together with a direction bit. The key loses its eight parity bits through the fixed first key permutation, giving two 28-bit halves. Each advance step rotates both halves, and the second fixed permutation compresses the rotated pair into a 48-bit subkey. The subkey output is combinational from the held halves, so the subkey for the current round is present in the cycle after each load or advance.

The direction bit selects the delivery order. In forward order (encryption) the first subkey comes out right after the load and each advance moves one round on. In reverse order (decryption) the sixteenth subkey comes out right after the load. This works without storing subkeys, because the cumulative left rotation over all sixteen rounds is exactly 28 places, which is the unrotated key. Each later advance rotates the halves right by the amount the round being left used. Both orders wrap around after sixteen advances, so a second block under the same key needs no reload.

Top module: `des_keysched`

## Requirements
- R1: While no key has been loaded since reset, `valid_o` is 0, `round_o` is 0 and `subkey_o` is all zeros, and a pulse on `next_i` has no effect.
- R2: A cycle with `load_i` high and `decrypt_i` low is followed by `valid_o`=1, `round_o`=0 and `subkey_o` equal to the first round subkey of `key_i`.
- R3: In forward mode each cycle with `next_i` high (and `load_i` low) raises `round_o` by one, and `subkey_o` becomes the subkey of that round. The rotation before rounds 1, 2, 9 and 16 is one place; before all other rounds it is two places.
- R4: A cycle with `load_i` and `decrypt_i` both high is followed by `valid_o`=1, `round_o`=15 and `subkey_o` equal to the sixteenth round subkey.
- R5: In reverse mode each advance lowers `round_o` by one, and `subkey_o` becomes the subkey of that round.
- R6: An advance wraps around: from round index 15 in forward mode it goes to index 0 with the first subkey, and from index 0 in reverse mode it goes to index 15 with the sixteenth subkey.
- R7: The parity bits of `key_i` (bit positions 0, 8, 16, ..., 56, with bit 63 the most significant) have no effect on any subkey.
- R8: When `load_i` and `next_i` are high in the same cycle, the load takes effect and the advance is dropped, so a load in the middle of a sequence restarts it.
- R9: With `load_i` and `next_i` both low, `subkey_o`, `round_o` and `valid_o` hold their values.
- R10: `decrypt_i` is sampled only in load cycles. Changing it during advances does not change the direction.
- R11: For key 0x133457799BBCDFF1 the first subkey is 0x1B02EFFC7072.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_i | input | 64 | DES key including parity bits, bit 63 is key bit 1 |
| load_i | input | 1 | Capture `key_i` and `decrypt_i`, start a new sequence |
| next_i | input | 1 | Advance to the next subkey in the selected order |
| decrypt_i | input | 1 | Order select at load: 0 forward, 1 reverse |
| subkey_o | output | 48 | Subkey for the current round, bit 47 is subkey bit 1 |
| round_o | output | 4 | Zero-based index of the current round |
| valid_o | output | 1 | A key has been loaded since reset |

## Verification
The checker's step properties take for granted that `load_i` and `next_i` are synchronous single-cycle-per-action strobes. They also take for granted that the direction applying to an advance is the one captured at the most recent load, which the checker tracks itself from `load_i` and `decrypt_i`. The bench keeps inside these limits by changing inputs only on the falling clock edge and by asserting a load before any sequence it scores. It deliberately toggles `decrypt_i` during advances and pulses `next_i` before the first load, so that the ignored-input cases are exercised at the ports.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;

    localparam int KEY_W    = 64;
    localparam int CD_W     = 56;
    localparam int HALF_W   = CD_W / 2;
    localparam int SUBKEY_W = 48;
    localparam int ROUNDS   = 16;
    localparam int RND_W    = $clog2(ROUNDS);

    // Rounds (zero-based) whose rotation is a single place; others use two.
    localparam logic [ROUNDS-1:0] ONE_STEP_MASK = 16'h8103;

    // Key permutation with parity drop: 1-based source bit positions, MSB first.
    localparam int unsigned KEY_SEL [CD_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    // Compression permutation: 1-based positions within the 56-bit halves pair.
    localparam int unsigned CMP_SEL [SUBKEY_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    typedef struct packed {
        logic [HALF_W-1:0] c;
        logic [HALF_W-1:0] d;
        logic [RND_W-1:0]  rnd;
        logic              dec;
        logic              vld;
    } ks_state_t;

endpackage

// File: rtl/des_ks_pc1.sv
module des_ks_pc1
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0]  key_i,
    output logic [HALF_W-1:0] c_o,
    output logic [HALF_W-1:0] d_o
);
    for (genvar i = 0; i < HALF_W; i++) begin : g_sel
        assign c_o[HALF_W-1-i] = key_i[KEY_W - KEY_SEL[i]];
        assign d_o[HALF_W-1-i] = key_i[KEY_W - KEY_SEL[HALF_W+i]];
    end
endmodule

// File: rtl/des_ks_rotate.sv
module des_ks_rotate #(
    parameter int W        = 28,
    parameter bit TO_RIGHT = 1'b0
) (
    input  logic [W-1:0] in_i,
    input  logic         by_two_i,
    output logic [W-1:0] out_o
);
    logic [W-1:0] by_one;
    logic [W-1:0] by_two;

    if (TO_RIGHT) begin : g_right
        assign by_one = {in_i[0],   in_i[W-1:1]};
        assign by_two = {in_i[1:0], in_i[W-1:2]};
    end else begin : g_left
        assign by_one = {in_i[W-2:0], in_i[W-1]};
        assign by_two = {in_i[W-3:0], in_i[W-1:W-2]};
    end

    assign out_o = by_two_i ? by_two : by_one;
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2
    import des_ks_pkg::*;
(
    input  logic [HALF_W-1:0]   c_i,
    input  logic [HALF_W-1:0]   d_i,
    output logic [SUBKEY_W-1:0] subkey_o
);
    logic [CD_W-1:0] cd;
    assign cd = {c_i, d_i};

    for (genvar i = 0; i < SUBKEY_W; i++) begin : g_sel
        assign subkey_o[SUBKEY_W-1-i] = cd[CD_W - CMP_SEL[i]];
    end
endmodule

// File: rtl/des_keysched.sv
module des_keysched
    import des_ks_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [KEY_W-1:0]    key_i,
    input  logic                load_i,
    input  logic                next_i,
    input  logic                decrypt_i,
    output logic [SUBKEY_W-1:0] subkey_o,
    output logic [RND_W-1:0]    round_o,
    output logic                valid_o
);
    ks_state_t st_d, st_q;

    logic [HALF_W-1:0] half_key [2];
    logic [HALF_W-1:0] half_q   [2];
    logic [HALF_W-1:0] half_ld  [2];
    logic [HALF_W-1:0] half_fw  [2];
    logic [HALF_W-1:0] half_bw  [2];
    logic [SUBKEY_W-1:0] cmp_out;
    logic [RND_W-1:0]    rnd_up;
    logic                two_up;
    logic                two_here;

    des_ks_pc1 u_pc1 (
        .key_i (key_i),
        .c_o   (half_key[0]),
        .d_o   (half_key[1])
    );

    assign half_q[0] = st_q.c;
    assign half_q[1] = st_q.d;

    // Forward step uses the amount of the round being entered,
    // backward step undoes the amount of the round being left.
    assign rnd_up   = st_q.rnd + RND_W'(1);
    assign two_up   = ~ONE_STEP_MASK[rnd_up];
    assign two_here = ~ONE_STEP_MASK[st_q.rnd];

    for (genvar h = 0; h < 2; h++) begin : g_half
        des_ks_rotate #(.W(HALF_W), .TO_RIGHT(1'b0)) u_rot_ld (
            .in_i     (half_key[h]),
            .by_two_i (~ONE_STEP_MASK[0]),
            .out_o    (half_ld[h])
        );
        des_ks_rotate #(.W(HALF_W), .TO_RIGHT(1'b0)) u_rot_fw (
            .in_i     (half_q[h]),
            .by_two_i (two_up),
            .out_o    (half_fw[h])
        );
        des_ks_rotate #(.W(HALF_W), .TO_RIGHT(1'b1)) u_rot_bw (
            .in_i     (half_q[h]),
            .by_two_i (two_here),
            .out_o    (half_bw[h])
        );
    end

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.dec = decrypt_i;
            st_d.vld = 1'b1;
            if (decrypt_i) begin
                // Total rotation over all rounds is a full turn.
                st_d.c   = half_key[0];
                st_d.d   = half_key[1];
                st_d.rnd = RND_W'(ROUNDS - 1);
            end else begin
                st_d.c   = half_ld[0];
                st_d.d   = half_ld[1];
                st_d.rnd = '0;
            end
        end else if (next_i && st_q.vld) begin
            if (st_q.dec) begin
                st_d.c   = half_bw[0];
                st_d.d   = half_bw[1];
                st_d.rnd = st_q.rnd - RND_W'(1);
            end else begin
                st_d.c   = half_fw[0];
                st_d.d   = half_fw[1];
                st_d.rnd = rnd_up;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    des_ks_pc2 u_pc2 (
        .c_i      (st_q.c),
        .d_i      (st_q.d),
        .subkey_o (cmp_out)
    );

    assign subkey_o = st_q.vld ? cmp_out : '0;
    assign round_o  = st_q.rnd;
    assign valid_o  = st_q.vld;
endmodule

// File: rtl/des_keysched_chk.sv
module des_keysched_chk
    import des_ks_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                load_i,
    input logic                next_i,
    input logic                decrypt_i,
    input logic [SUBKEY_W-1:0] subkey_o,
    input logic [RND_W-1:0]    round_o,
    input logic                valid_o
);
    logic dir_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)      dir_seen <= 1'b0;
        else if (load_i) dir_seen <= decrypt_i;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (subkey_o == '0 && round_o == '0)); // R1

    AST_LOAD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !decrypt_i) |=> (valid_o && round_o == '0)); // R2

    AST_LOAD_REV: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && decrypt_i) |=> (valid_o && round_o == RND_W'(ROUNDS - 1))); // R4

    AST_STEP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && next_i && valid_o && !dir_seen)
            |=> (round_o == RND_W'($past(round_o) + 1))); // R3

    AST_STEP_REV: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && next_i && valid_o && dir_seen)
            |=> (round_o == RND_W'($past(round_o) - 1))); // R5

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !next_i)
            |=> ($stable(subkey_o) && $stable(round_o) && $stable(valid_o))); // R9
endmodule

bind des_keysched des_keysched_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .next_i    (next_i),
    .decrypt_i (decrypt_i),
    .subkey_o  (subkey_o),
    .round_o   (round_o),
    .valid_o   (valid_o)
);

// File: tb/des_keysched_tb.sv
module des_keysched_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] key_i = '0;
    logic        load_i = 1'b0;
    logic        next_i = 1'b0;
    logic        decrypt_i = 1'b0;
    logic [47:0] subkey_o;
    logic [3:0]  round_o;
    logic        valid_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    des_keysched u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_i     (key_i),
        .load_i    (load_i),
        .next_i    (next_i),
        .decrypt_i (decrypt_i),
        .subkey_o  (subkey_o),
        .round_o   (round_o),
        .valid_o   (valid_o)
    );

    // Independent reference: subkey of round r from the cumulative rotation.
    int unsigned tb_p1 [56] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};
    int unsigned tb_p2 [48] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

    function automatic logic [47:0] ref_key(input logic [63:0] k, input int r);
        logic [27:0] c, d;
        logic [55:0] cd;
        logic [47:0] o;
        int rot;
        rot = 0;
        for (int i = 0; i <= r; i++)
            rot += (i == 0 || i == 1 || i == 8 || i == 15) ? 1 : 2;
        for (int i = 0; i < 28; i++) begin
            c[27-i] = k[64 - tb_p1[i]];
            d[27-i] = k[64 - tb_p1[28+i]];
        end
        for (int s = 0; s < rot; s++) begin
            c = {c[26:0], c[27]};
            d = {d[26:0], d[27]};
        end
        cd = {c, d};
        for (int i = 0; i < 48; i++) o[47-i] = cd[56 - tb_p2[i]];
        return o;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ld, input logic nx, input logic dec, input logic [63:0] k);
        @(negedge clk);
        load_i = ld; next_i = nx; decrypt_i = dec; key_i = k;
        @(posedge clk);
        #1;
        @(negedge clk);
        load_i = 1'b0; next_i = 1'b0;
    endtask

    task automatic run_key(input logic [63:0] k);
        // forward
        cyc(1'b1, 1'b0, 1'b0, k);
        check("R2 round", 64'(round_o), 64'd0);
        check("R2 valid", 64'(valid_o), 64'd1);
        check("R2 subkey", 64'(subkey_o), 64'(ref_key(k, 0)));
        for (int r = 1; r <= 16; r++) begin
            cyc(1'b0, 1'b1, r[0], ~k);          // R10: decrypt_i toggles, key_i changes
            check(r == 16 ? "R6 fwd wrap round" : "R3 round", 64'(round_o), 64'(r % 16));
            check(r == 16 ? "R6 fwd wrap subkey" : "R3 R10 subkey",
                  64'(subkey_o), 64'(ref_key(k, r % 16)));
        end
        // reverse
        cyc(1'b1, 1'b0, 1'b1, k);
        check("R4 round", 64'(round_o), 64'd15);
        check("R4 subkey", 64'(subkey_o), 64'(ref_key(k, 15)));
        for (int r = 14; r >= -1; r--) begin
            cyc(1'b0, 1'b1, r[0], ~k);
            check(r < 0 ? "R6 rev wrap round" : "R5 round", 64'(round_o), 64'((r + 16) % 16));
            check(r < 0 ? "R6 rev wrap subkey" : "R5 R10 subkey",
                  64'(subkey_o), 64'(ref_key(k, (r + 16) % 16)));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [63:0] k;
        logic [47:0] held;
        repeat (4) @(posedge clk);
        #1;
        check("R1 valid", 64'(valid_o), 64'd0);
        check("R1 round", 64'(round_o), 64'd0);
        check("R1 subkey", 64'(subkey_o), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 64'h0123456789ABCDEF);
        check("R1 next before load valid", 64'(valid_o), 64'd0);
        check("R1 next before load round", 64'(round_o), 64'd0);

        // R11 known vector
        cyc(1'b1, 1'b0, 1'b0, 64'h133457799BBCDFF1);
        check("R11 first subkey", 64'(subkey_o), 64'h1B02EFFC7072);

        run_key(64'h133457799BBCDFF1);
        run_key(64'h0000FFFF0000FFFF);
        run_key(64'h00000000FFFFFFFF);
        run_key(64'hFFFF0000FFFF0000);
        k = 64'h9E3779B97F4A7C15;
        for (int n = 0; n < 12; n++) begin
            run_key(k);
            k = k * 64'd6364136223846793005 + 64'd1442695040888963407;
        end

        // R7 parity bits ignored
        k = 64'hA5C3_0F1E_7788_9911;
        for (int p = 0; p < 2; p++) begin
            logic [63:0] kp;
            kp = k ^ (p == 0 ? 64'h0101010101010101 : 64'h0100010001000100);
            cyc(1'b1, 1'b0, 1'b0, kp);
            for (int r = 0; r < 16; r++) begin
                check("R7 parity ignored", 64'(subkey_o), 64'(ref_key(k, r)));
                cyc(1'b0, 1'b1, 1'b0, kp);
            end
        end

        // R8 load wins over next, mid-sequence restart
        cyc(1'b1, 1'b0, 1'b0, k);
        for (int r = 0; r < 5; r++) cyc(1'b0, 1'b1, 1'b0, k);
        cyc(1'b1, 1'b1, 1'b0, 64'h0F1E2D3C4B5A6978);
        check("R8 restart round", 64'(round_o), 64'd0);
        check("R8 restart subkey", 64'(subkey_o), 64'(ref_key(64'h0F1E2D3C4B5A6978, 0)));
        cyc(1'b1, 1'b1, 1'b1, k);
        check("R8 rev restart round", 64'(round_o), 64'd15);
        check("R8 rev restart subkey", 64'(subkey_o), 64'(ref_key(k, 15)));

        // R9 hold
        held = subkey_o;
        for (int r = 0; r < 3; r++) begin
            cyc(1'b0, 1'b0, 1'b0, ~k);
            check("R9 hold subkey", 64'(subkey_o), 64'(held));
            check("R9 hold round", 64'(round_o), 64'd15);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule